// File: doc/BRIEF.md
# Rectangular Cursor Outline Generator

This block marks the pixels of a hollow rectangle that a display pipeline overlays on the raster. Each cycle it takes the pixel column and line counters of the raster scan. From these and a set of cursor settings it decides whether the current pixel belongs to the rectangle's frame. When it does, the block returns the colour index and table selector that a later stage uses for the lookup. The lookup and the drawing of the colour are done elsewhere.

The frame thickness is given as codes, not as counts. The left and right edges use a 3-bit code that gives 1 pixel for code 0 and 4×code pixels otherwise. The top and bottom edges use a 3-bit code that gives 1 line for code 0 and 2×code lines otherwise.

The settings are sampled into an active copy on a frame-start pulse, so a rectangle never changes shape partway through a frame. In interlaced mode the line counter counts field lines, so the vertical origin, the height and the vertical thickness are all halved.

Top module: `cursor_frame_gen`

## Requirements
- R1: `hit_o` rises one clock after a pixel presented on `pix_x`/`pix_y`, and only for a pixel inside the active rectangle: column in [x, x+w) and line in [y, y+h).
- R2: A pixel inside the rectangle is a hit when its column lies within the horizontal thickness of the left edge or the right edge. The horizontal code c gives 1 pixel for c=0 and 4·c pixels for c=1..7.
- R3: A pixel inside the rectangle is a hit when its line lies within the vertical thickness of the top edge or the bottom edge. The vertical code c gives 1 line for c=0 and 2·c lines for c=1..7.
- R4: While the active enable is 0, `hit_o` stays 0 for every pixel.
- R5: On a hit, `idx_o` carries the 8-bit colour index and `ram_sel_o` carries the table selector (1 = RAM table, 0 = ROM table). Without a hit, both outputs are 0.
- R6: With the active interlace flag set, the vertical origin becomes y/2 and the height becomes h/2, both rounded down. The vertical thickness becomes the progressive value halved and rounded up.
- R7: Changes on the settings inputs have no effect until a `frame_start` pulse copies them into the active set. The new set applies from the cycle after the pulse.
- R8: After reset `hit_o`, `idx_o` and `ram_sel_o` are 0, and the active set is disabled until the first `frame_start`.
- R9: When a thickness reaches or exceeds half the rectangle's size on that axis, the edges merge and every pixel inside the rectangle is a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that loads the settings into the active set |
| pix_x | input | 11 | Current pixel column |
| pix_y | input | 11 | Current line (field line when interlaced) |
| cur_en | input | 1 | Cursor enable setting |
| cur_x | input | 11 | Left column of the rectangle |
| cur_y | input | 11 | Top line of the rectangle (frame lines) |
| cur_w | input | 11 | Rectangle width in pixels |
| cur_h | input | 11 | Rectangle height in frame lines |
| cur_hcode | input | 3 | Left/right edge thickness code |
| cur_vcode | input | 3 | Top/bottom edge thickness code |
| cur_ilace | input | 1 | Interlaced raster flag |
| cur_idx | input | 8 | Colour table index |
| cur_ram_sel | input | 1 | Table selector, 1 = RAM, 0 = ROM |
| hit_o | output | 1 | Registered cursor-hit flag |
| idx_o | output | 8 | Colour index of the hit pixel, 0 otherwise |
| ram_sel_o | output | 1 | Table selector of the hit pixel, 0 otherwise |

## Verification
The bench sweeps a window of the raster around each rectangle and compares every pixel. The window reaches into the first and last column and line inside each edge and one step outside them. A decoder that treats the thickness code as a plain count, or that drops the special case for code 0, therefore produces frames that are too thin or too thick. A right or bottom edge compare that is off by one either loses the outer column or lights the pixel just outside.

One sweep uses a thickness wider than half the rectangle. A design that subtracts the thickness from the far edge without care for wrap would then leave holes or mark pixels outside the rectangle.

Interlaced sweeps catch a design that leaves the height unhalved, or that rounds the 1-line thickness down to zero and loses the top and bottom edges. Sweeps run after reset without a frame pulse, and after settings change without a frame pulse. A design that used the live inputs directly would show a cursor there.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int CW  = 11;  // coordinate and size width
  localparam int IW  = 8;   // colour index width
  localparam int CDW = 3;   // thickness code width
  localparam int HTW = 5;   // decoded horizontal thickness width (max 28)
  localparam int VTW = 4;   // decoded vertical thickness width (max 14)

  typedef struct packed {
    logic           en;
    logic [CW-1:0]  x;
    logic [CW-1:0]  y;
    logic [CW-1:0]  w;
    logic [CW-1:0]  h;
    logic [CDW-1:0] hcode;
    logic [CDW-1:0] vcode;
    logic           ilace;
    logic [IW-1:0]  idx;
    logic           ram_sel;
  } cur_cfg_t;

  // Horizontal edge thickness: code 0 -> 1 pixel, else 4 * code
  function automatic logic [HTW-1:0] h_thick(input logic [CDW-1:0] code);
    return (code == '0) ? HTW'(1) : HTW'({code, 2'b00});
  endfunction

  // Vertical edge thickness: code 0 -> 1 line, else 2 * code
  function automatic logic [VTW-1:0] v_thick(input logic [CDW-1:0] code);
    return (code == '0) ? VTW'(1) : VTW'({code, 1'b0});
  endfunction

  // Field-line thickness: halved, rounded up so a 1-line edge survives
  function automatic logic [VTW-1:0] v_thick_field(input logic [VTW-1:0] t);
    return VTW'((VTW+1)'(t) + 1'b1 >> 1);
  endfunction
endpackage

// File: rtl/cursor_cfg_shadow.sv
module cursor_cfg_shadow
  import cursor_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  cur_cfg_t live,
  output cur_cfg_t act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act <= '0;
    else if (load) act <= live;
  end
endmodule

// File: rtl/cursor_thick_dec.sv
module cursor_thick_dec
  import cursor_pkg::*;
(
  input  logic [CDW-1:0] hcode,
  input  logic [CDW-1:0] vcode,
  input  logic           ilace,
  output logic [HTW-1:0] h_t,
  output logic [VTW-1:0] v_t
);
  logic [VTW-1:0] v_prog;
  always_comb begin
    h_t    = h_thick(hcode);
    v_prog = v_thick(vcode);
    v_t    = ilace ? v_thick_field(v_prog) : v_prog;
  end
endmodule

// File: rtl/cursor_hit_calc.sv
module cursor_hit_calc
  import cursor_pkg::*;
(
  input  logic [CW-1:0]  px,
  input  logic [CW-1:0]  py,
  input  cur_cfg_t       cfg,
  input  logic [HTW-1:0] h_t,
  input  logic [VTW-1:0] v_t,
  output logic           in_rect,
  output logic           on_edge
);
  localparam int EW = CW + 1;

  logic [CW-1:0] y0, hh, dx, dy;
  logic          in_x, in_y, e_l, e_r, e_t, e_b;

  always_comb begin
    y0   = cfg.ilace ? (cfg.y >> 1) : cfg.y;
    hh   = cfg.ilace ? (cfg.h >> 1) : cfg.h;
    in_x = ({1'b0, px} >= {1'b0, cfg.x}) &&
           ({1'b0, px} <  ({1'b0, cfg.x} + {1'b0, cfg.w}));
    in_y = ({1'b0, py} >= {1'b0, y0}) &&
           ({1'b0, py} <  ({1'b0, y0} + {1'b0, hh}));
    // offsets from the near edges, meaningful only inside the rectangle
    dx   = px - cfg.x;
    dy   = py - y0;
    e_l  = {1'b0, dx} < EW'(h_t);
    e_r  = ({1'b0, dx} + EW'(h_t)) >= {1'b0, cfg.w};
    e_t  = {1'b0, dy} < EW'(v_t);
    e_b  = ({1'b0, dy} + EW'(v_t)) >= {1'b0, hh};
    in_rect = in_x && in_y;
    on_edge = e_l || e_r || e_t || e_b;
  end
endmodule

// File: rtl/cursor_frame_gen.sv
module cursor_frame_gen
  import cursor_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic [CW-1:0] pix_x,
  input  logic [CW-1:0] pix_y,
  input  logic          cur_en,
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  input  logic [CW-1:0] cur_w,
  input  logic [CW-1:0] cur_h,
  input  logic [2:0]    cur_hcode,
  input  logic [2:0]    cur_vcode,
  input  logic          cur_ilace,
  input  logic [7:0]    cur_idx,
  input  logic          cur_ram_sel,
  output logic          hit_o,
  output logic [7:0]    idx_o,
  output logic          ram_sel_o
);
  cur_cfg_t       live_cfg, act_cfg;
  logic [HTW-1:0] h_t;
  logic [VTW-1:0] v_t;
  logic           in_rect, on_edge, act_en, hit_next;

  always_comb begin
    live_cfg = '{en: cur_en, x: cur_x, y: cur_y, w: cur_w, h: cur_h,
                 hcode: cur_hcode, vcode: cur_vcode, ilace: cur_ilace,
                 idx: cur_idx, ram_sel: cur_ram_sel};
  end

  cursor_cfg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .load(frame_start), .live(live_cfg), .act(act_cfg)
  );

  cursor_thick_dec u_dec (
    .hcode(act_cfg.hcode), .vcode(act_cfg.vcode), .ilace(act_cfg.ilace),
    .h_t(h_t), .v_t(v_t)
  );

  cursor_hit_calc u_calc (
    .px(pix_x), .py(pix_y), .cfg(act_cfg), .h_t(h_t), .v_t(v_t),
    .in_rect(in_rect), .on_edge(on_edge)
  );

  assign act_en   = act_cfg.en;
  assign hit_next = act_en && in_rect && on_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o     <= 1'b0;
      idx_o     <= '0;
      ram_sel_o <= 1'b0;
    end else begin
      hit_o     <= hit_next;
      idx_o     <= hit_next ? act_cfg.idx : '0;
      ram_sel_o <= hit_next && act_cfg.ram_sel;
    end
  end
endmodule

// File: rtl/cursor_frame_gen_chk.sv
module cursor_frame_gen_chk
  import cursor_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           frame_start,
  input cur_cfg_t       act_cfg,
  input logic           act_en,
  input logic           in_rect,
  input logic           on_edge,
  input logic [HTW-1:0] h_t,
  input logic [VTW-1:0] v_t,
  input logic           hit_o,
  input logic [7:0]     idx_o,
  input logic           ram_sel_o
);
  // R1: a hit only follows a pixel that was inside the rectangle
  a_r1_hit_inside: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(in_rect));

  // R2/R3: a hit only follows a pixel on one of the edge bands
  a_r2_hit_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(on_edge));

  // R2: decoded horizontal thickness stays within 1..28
  a_r2_hthick_range: assert property (@(posedge clk) disable iff (!rst_n)
    (h_t >= HTW'(1)) && (h_t <= HTW'(28)));

  // R3: decoded vertical thickness stays within 1..14
  a_r3_vthick_range: assert property (@(posedge clk) disable iff (!rst_n)
    (v_t >= VTW'(1)) && (v_t <= VTW'(14)));

  // R4: disabled active set gives no hit next cycle
  a_r4_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |=> !hit_o);

  // R5: colour outputs are quiet without a hit
  a_r5_quiet_color: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (idx_o == '0) && !ram_sel_o);

  // R7: active set holds between frame pulses
  a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_cfg));
endmodule

bind cursor_frame_gen cursor_frame_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .act_cfg(act_cfg),
  .act_en(act_en), .in_rect(in_rect), .on_edge(on_edge), .h_t(h_t), .v_t(v_t),
  .hit_o(hit_o), .idx_o(idx_o), .ram_sel_o(ram_sel_o)
);

// File: tb/cursor_frame_gen_bench.sv
module cursor_frame_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        frame_start = 1'b0;
  logic [10:0] pix_x = '0, pix_y = '0;
  logic        cur_en = 1'b0, cur_ilace = 1'b0, cur_ram_sel = 1'b0;
  logic [10:0] cur_x = '0, cur_y = '0, cur_w = '0, cur_h = '0;
  logic [2:0]  cur_hcode = '0, cur_vcode = '0;
  logic [7:0]  cur_idx = '0;
  logic        hit_o, ram_sel_o;
  logic [7:0]  idx_o;

  cursor_frame_gen u_cursor_frame_gen (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .pix_x(pix_x), .pix_y(pix_y), .cur_en(cur_en), .cur_x(cur_x),
    .cur_y(cur_y), .cur_w(cur_w), .cur_h(cur_h), .cur_hcode(cur_hcode),
    .cur_vcode(cur_vcode), .cur_ilace(cur_ilace), .cur_idx(cur_idx),
    .cur_ram_sel(cur_ram_sel), .hit_o(hit_o), .idx_o(idx_o),
    .ram_sel_o(ram_sel_o)
  );

  int n_tests = 0, n_fail = 0;

  typedef struct {
    bit     hit;
    bit [7:0] idx;
    bit     ram;
    int     px, py;
    string  req;
  } exp_t;
  exp_t sb[$];

  // model of the active set
  int m_en = 0, m_x, m_y, m_w, m_h, m_hc, m_vc, m_il, m_idx, m_ram;

  function automatic bit model_hit(int px, int py);
    int ht, vt, y0, hh;
    int ht_tab[8] = '{1, 4, 8, 12, 16, 20, 24, 28};
    int vt_tab[8] = '{1, 2, 4, 6, 8, 10, 12, 14};
    int vf_tab[8] = '{1, 1, 2, 3, 4, 5, 6, 7};
    ht = ht_tab[m_hc];
    vt = m_il ? vf_tab[m_vc] : vt_tab[m_vc];
    y0 = m_il ? m_y / 2 : m_y;
    hh = m_il ? m_h / 2 : m_h;
    if (m_en == 0) return 1'b0;
    if (px < m_x || px >= m_x + m_w || py < y0 || py >= y0 + hh) return 1'b0;
    return (px < m_x + ht) || (px >= m_x + m_w - ht) ||
           (py < y0 + vt) || (py >= y0 + hh - vt);
  endfunction

  logic drv_vld = 1'b0, pend = 1'b0;
  always @(posedge clk) pend <= drv_vld;

  // monitor: compare one cycle after each driven pixel
  always @(negedge clk) begin
    if (pend && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_tests++;
      if (hit_o !== e.hit) begin
        n_fail++;
        $display("FAIL %s hit at (%0d,%0d): got %0b expected %0b",
                 e.req, e.px, e.py, hit_o, e.hit);
      end
      n_tests++;
      if (idx_o !== e.idx || ram_sel_o !== e.ram) begin
        n_fail++;
        $display("FAIL R5 colour at (%0d,%0d): got %02h/%0b expected %02h/%0b",
                 e.px, e.py, idx_o, ram_sel_o, e.idx, e.ram);
      end
    end
  end

  task automatic drive_px(int px, int py, string req);
    exp_t e;
    @(negedge clk);
    pix_x = 11'(px);
    pix_y = 11'(py);
    e.hit = model_hit(px, py);
    e.idx = e.hit ? 8'(m_idx) : 8'h00;
    e.ram = e.hit ? (m_ram != 0) : 1'b0;
    e.px = px; e.py = py; e.req = req;
    sb.push_back(e);
    drv_vld = 1'b1;
  endtask

  task automatic scan(string req);
    for (int y = 0; y < 32; y++)
      for (int x = 0; x < 48; x++)
        drive_px(x, y, req);
    @(negedge clk);
    drv_vld = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(int en, int x, int y, int w, int h, int hc, int vc,
                         int il, int idx, int ram);
    @(negedge clk);
    drv_vld = 1'b0;
    cur_en = 1'(en); cur_x = 11'(x); cur_y = 11'(y); cur_w = 11'(w);
    cur_h = 11'(h); cur_hcode = 3'(hc); cur_vcode = 3'(vc);
    cur_ilace = 1'(il); cur_idx = 8'(idx); cur_ram_sel = 1'(ram);
  endtask

  task automatic new_frame();
    @(negedge clk);
    drv_vld = 1'b0;
    frame_start = 1'b1;
    m_en = cur_en; m_x = cur_x; m_y = cur_y; m_w = cur_w; m_h = cur_h;
    m_hc = cur_hcode; m_vc = cur_vcode; m_il = cur_ilace;
    m_idx = cur_idx; m_ram = cur_ram_sel;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state of outputs
    n_tests++;
    if (hit_o !== 1'b0 || idx_o !== 8'h00 || ram_sel_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R8 reset outputs: got %0b/%02h/%0b expected 0/00/0",
               hit_o, idx_o, ram_sel_o);
    end
    // R8: live settings enabled but no frame pulse yet -> nothing drawn
    set_cfg(1, 5, 3, 30, 20, 1, 2, 0, 8'hA5, 1);
    scan("R8");
    // R2: 4-pixel side edges, 4-line top/bottom
    new_frame();
    scan("R2");
    // R1: thinnest frame, rectangle bounds
    set_cfg(1, 10, 4, 12, 9, 0, 0, 0, 8'h3C, 0);
    new_frame();
    scan("R1");
    // R3: 14-line top/bottom on a 28-line box, 12-pixel sides
    set_cfg(1, 2, 1, 40, 28, 3, 7, 0, 8'h77, 1);
    new_frame();
    scan("R3");
    // R9: 28-pixel sides on a 30-pixel box merge
    set_cfg(1, 4, 2, 30, 16, 7, 1, 0, 8'hC3, 1);
    new_frame();
    scan("R9");
    // R6: interlaced halving of origin, height and thickness
    set_cfg(1, 6, 9, 20, 31, 2, 3, 1, 8'h5A, 0);
    new_frame();
    scan("R6");
    set_cfg(1, 3, 5, 25, 41, 5, 0, 1, 8'h11, 1);
    new_frame();
    scan("R6");
    // R4: disabled
    set_cfg(0, 0, 0, 40, 30, 0, 0, 0, 8'hFF, 1);
    new_frame();
    scan("R4");
    // R7: change settings without a frame pulse -> still disabled
    set_cfg(1, 0, 0, 8, 8, 0, 0, 0, 8'h42, 1);
    scan("R7");
    // R7: after the pulse the new set applies, corner at the origin
    new_frame();
    scan("R7");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule